// File: doc/BRIEF.md
# Command-Framed Serial Peripheral Slave

This block is the target side of a four-wire synchronous serial link: a serial clock driven by the remote master, an active-low select, a data line into the block and a data line out of it. All internal logic runs on the system clock. The three incoming wires each pass through a two-stage synchroniser. Serial clock edges are found by comparing successive synchronised samples, so the system clock has to run at least four times faster than the serial clock. Transfers use clock mode 0 with the most significant bit first. Incoming data is sampled on rising serial clock edges, and outgoing data changes after falling edges.

Only the master can open a transfer, which it does by pulling select low. The first byte shifted in during a select window is reported as a command byte. Any number of data bytes may follow, and each is reported as data. The master ends the transfer by releasing select. If it releases select partway through a byte, the partial byte is thrown away, an abort pulse is raised and the block returns to idle.

Received bytes leave on a valid/data stream with a one-cycle strobe. This stream has no back-pressure: the consumer must take every beat in the cycle it appears. Outgoing bytes arrive on a valid/ready stream. At each byte boundary the block raises `tx_ready_o` for exactly one cycle, and it takes the offered byte only if `tx_valid_i` is high in that same cycle. It never waits for the source. A source that is late causes an underrun, and the block sends zero in that byte.

Top module: `spi_cmd_slave`

## Requirements
- R1: Data on `mosi_i` is sampled on rising `sclk_i` edges, most significant bit first. After the eighth rising edge of a byte, that byte appears on `rx_data_o` with `rx_valid_o` high for exactly one cycle.
- R2: `rx_is_cmd_o` is 1 with the first byte received in each select window and 0 with every later byte in that window. A new window always starts again with a command byte.
- R3: A select window may carry any number of data bytes after the command byte. Each byte is delivered separately, in order.
- R4: `miso_o` carries the outgoing byte most significant bit first. The first bit is driven as soon as select is recognised, or right after the previous byte completes. Later bits change after falling `sclk_i` edges.
- R5: `tx_ready_o` pulses for one cycle at each byte boundary: once when select is recognised and once after every completed byte. The byte on `tx_data_i` is taken when `tx_valid_i` and `tx_ready_o` are both high.
- R6: If `tx_valid_i` is low at a byte boundary, that byte is sent as 0x00 and `underrun_o` pulses for one cycle.
- R7: Releasing select after one to seven bits of a byte discards the partial byte (no `rx_valid_o`), pulses `abort_o` for one cycle and returns the block to idle. Releasing select at a byte boundary raises no abort.
- R8: `miso_oe_o` is 1 while select is active and 0 otherwise. `miso_o` is 0 whenever `miso_oe_o` is 0.
- R9: Activity on `sclk_i` and `mosi_i` while select is inactive has no effect: it produces no `rx_valid_o`, no `tx_ready_o` and no `underrun_o`.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| ssel_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data line to the master |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_is_cmd_o | output | 1 | High when the received byte is the command byte |
| rx_data_o | output | 8 | Received byte value |
| tx_data_i | input | 8 | Byte offered for transmission |
| tx_valid_i | input | 1 | Transmit byte is present |
| tx_ready_o | output | 1 | One-cycle pulse: the block takes a byte at this boundary |
| underrun_o | output | 1 | One-cycle pulse: no transmit byte was present at a boundary |
| abort_o | output | 1 | One-cycle pulse: select was released mid-byte |

## Verification
The assertions check four things on every cycle: the receive strobe and the transmit-ready pulse never last longer than one cycle, the output line stays low while it is disabled or while a byte is being replaced by zero, and an abort never coincides with an enabled output or a delivered byte. Other behaviours can only be shown by the bench's scenarios, because they depend on the bit values carried across whole transactions. These are: bit order in both directions, the command flag on the first byte of each window, the count of handshake pulses and underruns per transfer, the discarding of a partial byte, and the block ignoring clocks while deselected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic {
    LINK_IDLE   = 1'b0,
    LINK_ACTIVE = 1'b1
  } link_state_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic ssel_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_start,
  output logic sel_end
);
  logic sclk_d;
  logic ssel_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      ssel_n_d <= 1'b1;
    end else begin
      sclk_d   <= sclk_s;
      ssel_n_d <= ssel_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign sel_start = ~ssel_n_s & ssel_n_d;
  assign sel_end   = ssel_n_s & ~ssel_n_d;
endmodule

// File: rtl/spi_frame_core.sv
module spi_frame_core
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rx_valid_o,
  output logic              rx_is_cmd_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              underrun_o,
  output logic              abort_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  link_state_t       state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_sh_q;
  logic [BYTE_W-1:0] tx_sh_q;
  logic              first_q;
  logic              byte_done;
  logic              load_now;
  logic [BYTE_W-1:0] load_val;
  logic [BYTE_W-1:0] rx_next;

  assign byte_done = (state_q == LINK_ACTIVE) && !sel_end && sclk_rise
                     && (bit_cnt_q == LAST_BIT);
  assign load_now  = ((state_q == LINK_IDLE) && sel_start) || byte_done;
  assign load_val  = tx_valid_i ? tx_data_i : '0;
  assign rx_next   = {rx_sh_q[BYTE_W-2:0], mosi_s};
  assign tx_ready_o = load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LINK_IDLE;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      first_q     <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_is_cmd_o <= 1'b0;
      rx_data_o   <= '0;
      underrun_o  <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      underrun_o <= 1'b0;
      abort_o    <= 1'b0;
      unique case (state_q)
        LINK_IDLE: begin
          if (sel_start) begin
            state_q    <= LINK_ACTIVE;
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            first_q    <= 1'b1;
            tx_sh_q    <= load_val;
            underrun_o <= !tx_valid_i;
          end
        end
        LINK_ACTIVE: begin
          if (sel_end) begin
            // R7: release of select wins over any edge seen in the same cycle
            state_q   <= LINK_IDLE;
            abort_o   <= (bit_cnt_q != '0);
            bit_cnt_q <= '0;
            tx_sh_q   <= '0;
          end else if (sclk_rise) begin
            rx_sh_q <= rx_next;
            if (bit_cnt_q == LAST_BIT) begin
              bit_cnt_q   <= '0;
              rx_valid_o  <= 1'b1;
              rx_data_o   <= rx_next;
              rx_is_cmd_o <= first_q;
              first_q     <= 1'b0;
              tx_sh_q     <= load_val;
              underrun_o  <= !tx_valid_i;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else if (sclk_fall && (bit_cnt_q != '0)) begin
            tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
          end
        end
        default: state_q <= LINK_IDLE;
      endcase
    end
  end

  assign miso_oe_o = (state_q == LINK_ACTIVE);
  assign miso_o    = miso_oe_o & tx_sh_q[BYTE_W-1];

  // R1: a received byte is strobed for a single cycle
  a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R5: the transmit handshake opens for a single cycle per boundary
  a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);

  // R6: an underrun byte starts with a zero on the line
  a_r6_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> !miso_o);

  // R7: an abort leaves the link idle with nothing delivered
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!miso_oe_o && !rx_valid_o));

  // R8: a disabled output line is held low
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> !miso_o);

  // R9: no byte is delivered while deselected
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> !rx_valid_o);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              ssel_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rx_valid_o,
  output logic              rx_is_cmd_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              underrun_o,
  output logic              abort_o
);
  logic [2:0] pins_s;
  logic       sclk_rise;
  logic       sclk_fall;
  logic       sel_start;
  logic       sel_end;

  // bit order {mosi, select_n, sclk}; select_n resets inactive (high)
  spi_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({mosi_i, ssel_n_i, sclk_i}),
    .sync_o (pins_s)
  );

  spi_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[0]),
    .ssel_n_s (pins_s[1]),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .sel_start(sel_start),
    .sel_end  (sel_end)
  );

  spi_frame_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .mosi_s     (pins_s[2]),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .rx_valid_o (rx_valid_o),
    .rx_is_cmd_o(rx_is_cmd_o),
    .rx_data_o  (rx_data_o),
    .underrun_o (underrun_o),
    .abort_o    (abort_o)
  );
endmodule

// File: tb/spi_cmd_slave_test.sv
module spi_cmd_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       ssel_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso, miso_oe, rx_valid, rx_is_cmd, tx_ready, underrun, abort_p;
  logic [7:0] rx_data, tx_data;
  logic       tx_valid;

  int checks = 0;
  int errors = 0;

  int tx_idx, tx_cnt;
  logic [7:0] tx_mem [64];
  int rx_n = 0, un_n = 0, ab_n = 0, rd_n = 0;
  logic [8:0] rx_log [64];

  always #4 clk = ~clk;

  spi_cmd_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ssel_n_i(ssel_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_valid_o(rx_valid),
    .rx_is_cmd_o(rx_is_cmd), .rx_data_o(rx_data), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .underrun_o(underrun),
    .abort_o(abort_p)
  );

  // transmit source model
  assign tx_valid = (tx_idx < tx_cnt);
  assign tx_data  = tx_mem[tx_idx[5:0]];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_idx <= 0;
    else if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin rx_log[rx_n[5:0]] = {rx_is_cmd, rx_data}; rx_n++; end
      if (underrun) un_n++;
      if (abort_p)  ab_n++;
      if (tx_ready) rd_n++;
    end
  end

  typedef struct packed {
    logic [1:0]  len;
    logic [1:0]  avail;
    logic [23:0] mo;
    logic [23:0] tx;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd1, 2'd2, 24'hA50000, 24'h3C7700},
    '{2'd3, 2'd2, 24'h817E00, 24'hC35A00},
    '{2'd2, 2'd3, 24'hFF0100, 24'h8001EE},
    '{2'd3, 2'd0, 24'h123456, 24'h999999}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = mo[b];
      tick(4);
      mi[b] = miso;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_on();
    ssel_n = 1'b0;
    tick(8);
  endtask

  task automatic sel_off();
    tick(4);
    ssel_n = 1'b1;
    tick(8);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int rx0, un0, ab0, rd0;
    tx_cnt = 0;
    for (int i = 0; i < 64; i++) tx_mem[i] = '0;
    tick(3);
    // R10: outputs idle during reset
    chk("R10 outputs in reset", {miso, miso_oe, rx_valid, tx_ready, underrun, abort_p}, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R10 outputs after reset", {miso, miso_oe, rx_valid, tx_ready, underrun, abort_p}, 0);

    // table-driven transfers: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      vec_t cv;
      int base;
      cv = VECS[v];
      base = tx_idx;
      for (int k = 0; k < 3; k++) tx_mem[(base + k) % 64] = cv.tx[23 - 8*k -: 8];
      tx_cnt = base + int'(cv.avail);
      rx0 = rx_n; un0 = un_n; rd0 = rd_n; ab0 = ab_n;
      sel_on();
      chk("R8 oe while selected", miso_oe, 1);
      for (int k = 0; k < int'(cv.len); k++) begin
        logic [7:0] exp_mi;
        shift_bits(cv.mo[23 - 8*k -: 8], 8, got);
        exp_mi = (k < int'(cv.avail)) ? cv.tx[23 - 8*k -: 8] : 8'h00;
        chk("R4 R6 miso byte", got, exp_mi);
      end
      sel_off();
      chk("R3 byte count", rx_n - rx0, cv.len);
      for (int k = 0; k < int'(cv.len); k++) begin
        chk("R1 rx data", rx_log[(rx0 + k) % 64][7:0], cv.mo[23 - 8*k -: 8]);
        chk("R2 cmd flag", rx_log[(rx0 + k) % 64][8], (k == 0));
      end
      chk("R5 ready pulses", rd_n - rd0, int'(cv.len) + 1);
      chk("R6 underruns", un_n - un0,
          (int'(cv.len) + 1 > int'(cv.avail)) ? int'(cv.len) + 1 - int'(cv.avail) : 0);
      chk("R7 no abort on whole bytes", ab_n - ab0, 0);
      chk("R8 oe after release", {miso_oe, miso}, 0);
      tx_cnt = tx_idx;
    end

    // R7: release after three bits
    rx0 = rx_n; ab0 = ab_n;
    sel_on();
    shift_bits(8'hF0, 3, got);
    sel_off();
    chk("R7 abort pulse", ab_n - ab0, 1);
    chk("R7 partial discarded", rx_n - rx0, 0);
    chk("R7 idle after abort", miso_oe, 0);

    // R7: select without any clock gives no abort
    ab0 = ab_n; rx0 = rx_n;
    sel_on();
    sel_off();
    chk("R7 no abort at boundary", ab_n - ab0, 0);
    chk("R7 nothing received", rx_n - rx0, 0);

    // R2: framing restarts after an abort
    rx0 = rx_n;
    sel_on();
    shift_bits(8'h6D, 8, got);
    shift_bits(8'h92, 8, got);
    sel_off();
    chk("R2 count after abort", rx_n - rx0, 2);
    chk("R2 cmd after abort", rx_log[rx0 % 64], {1'b1, 8'h6D});
    chk("R2 data after abort", rx_log[(rx0 + 1) % 64], {1'b0, 8'h92});

    // R9: clocks while deselected are ignored
    rx0 = rx_n; un0 = un_n; rd0 = rd_n;
    mosi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
    end
    chk("R9 no rx while idle", rx_n - rx0, 0);
    chk("R9 no ready while idle", rd_n - rd0, 0);
    chk("R9 no underrun while idle", un_n - un0, 0);
    chk("R8 line off while idle", {miso_oe, miso}, 0);

    finish_run();
  end
endmodule